// File: doc/BRIEF.md
# Audio capture FIFO with output formatting

This block sits between an ADC digital front end and a bus reader. Each cycle with a valid strobe, the front end offers a left and a right 24-bit sample. The block stores these samples in a shared array of 24-bit slots. A reader pops one slot per read strobe and receives it as a 32-bit word. The word is laid out for the selected resolution and alignment.

In stereo capture, a frame takes two slots, left then right. In mono capture, only the left sample is stored, so the same array holds twice as many entries. The block reports a fill level in entries and raises a request line when the fill reaches a programmable trigger level.

After the converter is enabled, an optional settling timer blocks writes for a chosen number of milliseconds, counted from the clock frequency parameter. Turning the converter off, or switching between mono and stereo, empties the store. Sticky flags record dropped writes and reads made while the store was empty.

Top module: `audio_capture_fifo`

## Requirements
- R1: While `adc_en` is low, no sample is stored, the fill level is 0 from the next cycle on, and both sticky flags read 0.
- R2: In stereo mode (`mono_en`=0), a valid strobe stores the left sample and then the right sample, for a capacity of 16 frames. In mono mode (`mono_en`=1), only the left sample is stored, for a capacity of 32 entries.
- R3: With `res24`=1, `rd_data` is the 24-bit sample in bits 31:8 with zeros in bits 7:0. The `align_sx` input has no effect in this resolution.
- R4: With `res24`=0 and `align_sx`=0, `rd_data` is sample bits 23:8 placed in bits 31:16, with zeros in bits 15:0.
- R5: With `res24`=0 and `align_sx`=1, `rd_data` is sample bits 23:8 in bits 15:0, with sample bit 23 copied into bits 31:16.
- R6: With `hold_en`=1, writes are blocked for N cycles starting at the cycle where `adc_en` rises. N = ms × (CLK_HZ/1000), where `hold_sel` codes 0, 1, 2 and 3 select 5, 10, 20 and 30 ms.
- R7: The settling timer restarts on every new rise of `adc_en` and is cancelled when `adc_en` falls. If `hold_en` is 0 at the rise, the first write is accepted in the rise cycle.
- R8: `req` is 1 exactly when `fill_level` ≥ min(`trig_level`, current capacity), where capacity is 16 in stereo mode and 32 in mono mode.
- R9: `fill_level` counts stored slots in mono mode and stored slots divided by two, rounded down, in stereo mode. Reads pop one slot each, oldest first.
- R10: A strobe that finds fewer free slots than it needs stores nothing and sets the sticky `overrun` flag.
- R11: With the store empty, `rd_data` is 0. A read strobe pops nothing and sets the sticky `underrun` flag.
- R12: A change of `mono_en` while enabled empties the store in that cycle. No read or write is performed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_en | input | 1 | Converter data path enable |
| mono_en | input | 1 | 1: mono capture, 0: stereo |
| res24 | input | 1 | 1: 24-bit samples, 0: 16-bit |
| align_sx | input | 1 | 16-bit layout: 1 sign-extended low half, 0 high half |
| hold_en | input | 1 | Enable post-enable write hold-off |
| hold_sel | input | 2 | Hold-off length code |
| trig_level | input | 5 | Request threshold in entries |
| smp_valid | input | 1 | Sample pair strobe |
| smp_left | input | 24 | Left sample |
| smp_right | input | 24 | Right sample |
| rd_en | input | 1 | Read strobe, pops one slot |
| rd_data | output | 32 | Formatted head word |
| fill_level | output | 6 | Stored entries |
| req | output | 1 | Interrupt/DMA request |
| overrun | output | 1 | Sticky dropped-write flag |
| underrun | output | 1 | Sticky empty-read flag |

## Verification
The bench builds the block with CLK_HZ set to 2000, so one millisecond is two clock cycles. With that setting, every hold-off length ends within 60 cycles, and the bench can observe the exact end of each window for all four codes. The store size keeps its default of 32 slots, so both capacities, overrun in either mode and trigger values above the stereo capacity can all be reached in short bursts.

// File: rtl/acf_pkg.sv
package acf_pkg;
  localparam int SMP_W = 24;
  localparam int WORD_W = 32;

  // Lays out one stored sample as a bus word.
  function automatic logic [WORD_W-1:0] fmt_word(input logic [SMP_W-1:0] s,
                                                 input logic res24,
                                                 input logic sx);
    logic [WORD_W-1:0] w;
    if (res24)   w = {s, 8'h00};
    else if (sx) w = {{16{s[SMP_W-1]}}, s[SMP_W-1:8]};
    else         w = {s[SMP_W-1:8], 16'h0000};
    return w;
  endfunction

  // Hold-off length in clock cycles for a 2-bit code.
  function automatic int unsigned hold_cycles(input logic [1:0] sel,
                                              input int unsigned clk_hz);
    int unsigned ms;
    case (sel)
      2'd0:    ms = 5;
      2'd1:    ms = 10;
      2'd2:    ms = 20;
      default: ms = 30;
    endcase
    return ms * (clk_hz / 1000);
  endfunction
endpackage

// File: rtl/acf_holdoff.sv
module acf_holdoff #(
  parameter int unsigned CLK_HZ = 24576000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       func_en,
  input  logic [1:0] sel,
  output logic       block
);
  import acf_pkg::*;
  localparam int unsigned MAXC = 30 * (CLK_HZ / 1000);
  localparam int TW = $clog2(MAXC + 1);

  logic [TW-1:0] cnt;
  logic          en_q;
  logic          rise;

  assign rise  = en & ~en_q;
  assign block = en & ((func_en & rise) | (cnt != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      en_q <= 1'b0;
    end else begin
      en_q <= en;
      if (!en)                cnt <= '0;
      else if (rise && func_en) cnt <= TW'(hold_cycles(sel, CLK_HZ) - 1);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/acf_store.sv
module acf_store #(
  parameter int W  = 24,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          pop,
  input  logic [1:0]    push_n,
  input  logic [W-1:0]  d0,
  input  logic [W-1:0]  d1,
  output logic [W-1:0]  head,
  output logic [AW:0]   words
);
  localparam int N = 1 << AW;

  logic [W-1:0]  mem [N];
  logic [AW-1:0] wp, rp;
  logic [AW-1:0] wp1;

  assign wp1  = wp + 1'b1;
  assign head = mem[rp];

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wp] <= d0;
    if (push_n == 2'd2) mem[wp1] <= d1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      words <= '0;
    end else begin
      wp    <= wp + AW'(push_n);
      rp    <= rp + AW'(pop);
      words <= words + (AW+1)'(push_n) - (AW+1)'(pop);
    end
  end
endmodule

// File: rtl/acf_format.sv
module acf_format (
  input  logic        valid,
  input  logic [23:0] smp,
  input  logic        res24,
  input  logic        sx,
  output logic [31:0] word
);
  import acf_pkg::*;
  assign word = valid ? fmt_word(smp, res24, sx) : 32'h0;
endmodule

// File: rtl/audio_capture_fifo.sv
module audio_capture_fifo #(
  parameter int unsigned CLK_HZ = 24576000,
  parameter int          AW     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adc_en,
  input  logic        mono_en,
  input  logic        res24,
  input  logic        align_sx,
  input  logic        hold_en,
  input  logic [1:0]  hold_sel,
  input  logic [4:0]  trig_level,
  input  logic        smp_valid,
  input  logic [23:0] smp_left,
  input  logic [23:0] smp_right,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic [5:0]  fill_level,
  output logic        req,
  output logic        overrun,
  output logic        underrun
);
  localparam int SLOTS = 1 << AW;
  localparam int CAP_M = SLOTS;
  localparam int CAP_S = SLOTS / 2;

  logic          mono_q;
  logic          wr_block;
  logic          flush_now;
  logic [AW:0]   words;
  logic [AW:0]   free_slots;
  logic [AW:0]   need;
  logic          wr_try, wr_ok, pop_ok;
  logic          ovr_evt, und_evt;
  logic [1:0]    push_n;
  logic [23:0]   head;
  logic [AW:0]   cap, trig_eff;

  acf_holdoff #(.CLK_HZ(CLK_HZ)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(adc_en), .func_en(hold_en),
    .sel(hold_sel), .block(wr_block));

  assign flush_now  = ~adc_en | (mono_en ^ mono_q);
  assign free_slots = (AW+1)'(SLOTS) - words;
  assign need       = mono_en ? (AW+1)'(1) : (AW+1)'(2);
  assign wr_try     = smp_valid & ~wr_block & ~flush_now;
  assign wr_ok      = wr_try & (free_slots >= need);
  assign ovr_evt    = wr_try & ~wr_ok;
  assign pop_ok     = rd_en & ~flush_now & (words != '0);
  assign und_evt    = rd_en & ~flush_now & (words == '0);
  assign push_n     = wr_ok ? (mono_en ? 2'd1 : 2'd2) : 2'd0;

  acf_store #(.W(24), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_now), .pop(pop_ok),
    .push_n(push_n), .d0(smp_left), .d1(smp_right),
    .head(head), .words(words));

  acf_format u_fmt (
    .valid(words != '0), .smp(head), .res24(res24), .sx(align_sx),
    .word(rd_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mono_q   <= 1'b0;
      overrun  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      mono_q <= mono_en;
      if (!adc_en) begin
        overrun  <= 1'b0;
        underrun <= 1'b0;
      end else begin
        if (ovr_evt) overrun  <= 1'b1;
        if (und_evt) underrun <= 1'b1;
      end
    end
  end

  assign fill_level = 6'(mono_en ? words : (words >> 1));
  assign cap        = mono_en ? (AW+1)'(CAP_M) : (AW+1)'(CAP_S);
  assign trig_eff   = ((AW+1)'(trig_level) > cap) ? cap : (AW+1)'(trig_level);
  assign req        = (AW+1)'(fill_level) >= trig_eff;
endmodule

// File: rtl/audio_capture_fifo_chk.sv
module audio_capture_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        adc_en,
  input logic        mono_en,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic [5:0]  fill_level,
  input logic        req,
  input logic        overrun,
  input logic        underrun,
  input logic        wr_block,
  input logic        flush_now,
  input logic [5:0]  words
);
  AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |=> (fill_level == 6'd0 && !overrun && !underrun)); // R1
  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= (mono_en ? 6'd32 : 6'd16)); // R2
  AST_HOLDOFF_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |=> (words <= $past(words))); // R6
  AST_FULL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == (mono_en ? 6'd32 : 6'd16)) |-> req); // R8
  AST_STICKY_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && adc_en) |=> overrun); // R10
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (words == 6'd0) |-> (rd_data == 32'h0)); // R11
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && words == 6'd0 && !flush_now) |=> underrun); // R11
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en && flush_now) |=> (words == 6'd0)); // R12
endmodule

bind audio_capture_fifo audio_capture_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .mono_en(mono_en),
  .rd_en(rd_en), .rd_data(rd_data), .fill_level(fill_level), .req(req),
  .overrun(overrun), .underrun(underrun), .wr_block(wr_block),
  .flush_now(flush_now), .words(6'(words)));

// File: tb/audio_capture_fifo_test.sv
module audio_capture_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ = 2000;
  localparam int CPMS = CLK_HZ / 1000;

  logic clk = 0, rst_n = 0;
  logic adc_en = 0, mono_en = 0, res24 = 1, align_sx = 0, hold_en = 0;
  logic [1:0] hold_sel = 0;
  logic [4:0] trig_level = 5'd15;
  logic smp_valid = 0, rd_en = 0;
  logic [23:0] smp_left = 0, smp_right = 0;
  logic [31:0] rd_data;
  logic [5:0] fill_level;
  logic req, overrun, underrun;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R9";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_capture_fifo #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .mono_en(mono_en),
    .res24(res24), .align_sx(align_sx), .hold_en(hold_en),
    .hold_sel(hold_sel), .trig_level(trig_level), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .rd_en(rd_en),
    .rd_data(rd_data), .fill_level(fill_level), .req(req),
    .overrun(overrun), .underrun(underrun));

  // Behavioural reference
  logic [23:0] q[$];
  bit m_en_q, m_mono_q, m_ovr, m_und;
  int m_cnt;

  function automatic int ms_of(input logic [1:0] s);
    int t[4] = '{5, 10, 20, 30};
    return t[s];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_en_q = 0; m_mono_q = 0; m_ovr = 0; m_und = 0; m_cnt = 0;
    end else begin
      bit rise, blk, fl;
      int sz;
      rise = adc_en && !m_en_q;
      blk  = adc_en && ((hold_en && rise) || m_cnt > 0);
      fl   = !adc_en || (mono_en != m_mono_q);
      sz   = q.size();
      if (fl) q.delete();
      else begin
        if (rd_en) begin
          if (sz > 0) void'(q.pop_front());
          else m_und = 1;
        end
        if (smp_valid && !blk) begin
          if (32 - sz >= (mono_en ? 1 : 2)) begin
            q.push_back(smp_left);
            if (!mono_en) q.push_back(smp_right);
          end else m_ovr = 1;
        end
      end
      if (!adc_en) begin m_ovr = 0; m_und = 0; end
      if (!adc_en) m_cnt = 0;
      else if (rise && hold_en) m_cnt = ms_of(hold_sel) * CPMS - 1;
      else if (m_cnt > 0) m_cnt--;
      m_en_q = adc_en; m_mono_q = mono_en;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int lvl, cap, te;
      logic [31:0] w;
      logic [23:0] s;
      cycles++;
      lvl = mono_en ? q.size() : q.size() / 2;
      cap = mono_en ? 32 : 16;
      te  = (trig_level > cap) ? cap : trig_level;
      w = 0;
      if (q.size() > 0) begin
        s = q[0];
        if (res24) w = {s, 8'h00};
        else if (align_sx) w = {{16{s[23]}}, s[23:8]};
        else w = {s[23:8], 16'h0};
      end
      chk(q.size() == 0 ? "R11 empty data" : res24 ? "R3 data" :
          align_sx ? "R5 data" : "R4 data", rd_data, w);
      chk({phase, " level"}, fill_level, lvl);
      chk("R8 req", req, lvl >= te);
      chk("R10 overrun", overrun, m_ovr);
      chk("R11 underrun", underrun, m_und);
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      smp_left = 24'($urandom); smp_right = 24'($urandom);
    end
  endtask

  task automatic mix(input int n);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'($urandom); rd_en = 1'($urandom);
      tick();
    end
    smp_valid = 0; rd_en = 0;
  endtask

  initial begin
    tick(3); rst_n = 1;
    // R1: strobes while disabled
    phase = "R1"; smp_valid = 1; tick(10);
    // R2, R10: stereo fill past 16 frames
    phase = "R2"; adc_en = 1; tick(20);
    // R11: drain and over-read
    smp_valid = 0; rd_en = 1; phase = "R9"; tick(36); rd_en = 0;
    phase = "R1"; adc_en = 0; tick(2);
    // R2, R4: mono, 16-bit high half
    phase = "R2"; mono_en = 1; res24 = 0; align_sx = 0; adc_en = 1;
    smp_valid = 1; tick(40); smp_valid = 0; rd_en = 1; tick(34); rd_en = 0;
    // R5: sign-extended layout
    phase = "R9"; align_sx = 1; mix(60);
    // R12: mode switch with data held
    smp_valid = 1; tick(10); phase = "R12"; mono_en = 0; tick(5);
    smp_valid = 0; mix(20);
    // R3: 24-bit ignores align_sx
    res24 = 1; align_sx = 1; mix(40); align_sx = 0; mix(20);
    // R8: trigger sweep, including above stereo capacity
    phase = "R9";
    foreach (trig_level_set[i]) begin
      trig_level = trig_level_set[i];
      mono_en = 1'(i % 2); smp_valid = 1; tick(35); mix(30);
    end
    trig_level = 5'd15; mono_en = 0;
    // R6: each hold-off code
    for (int s = 0; s < 4; s++) begin
      phase = "R6"; adc_en = 0; tick(2);
      hold_en = 1; hold_sel = 2'(s); adc_en = 1; smp_valid = 1;
      tick(ms_of(2'(s)) * CPMS + 4); smp_valid = 0; rd_en = 1; tick(20); rd_en = 0;
    end
    // R7: restart mid-window, and rise without hold-off
    phase = "R7"; adc_en = 0; tick(2); hold_sel = 2'd1; adc_en = 1; smp_valid = 1;
    tick(7); adc_en = 0; tick(1); adc_en = 1; tick(25);
    adc_en = 0; tick(1); hold_en = 0; adc_en = 1; tick(3);
    smp_valid = 0; mix(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  logic [4:0] trig_level_set[4] = '{5'd0, 5'd7, 5'd20, 5'd31};
endmodule